// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration bitstream into a downstream programmable device over a three-wire passive serial link: an active-low configuration request, a serial clock and one data line. A start pulse launches a load and captures the byte count. The block first performs a reset handshake with the device. It holds the request low for a fixed time. It then checks that the device's active-low status line answers. It releases the request and waits, with a timeout, for the device to release its status line.

Bitstream bytes arrive on a valid/ready byte stream. Each byte goes out least significant bit first. The data bit is placed while the clock is low, and the device samples it on the rising edge. Once the last byte has gone out, the block checks the device's done input. If done is set, the block sends a fixed burst of trailing clocks and reports success. Any check that fails ends the load with a two-bit error code. An abort input stops a load at any point. All timings are parameters counted in system clock cycles. The clock half-period parameter keeps the serial clock below the device's 50 MHz limit.

Top module: `ps_cfg_master`

## Requirements
- R1: After a start pulse is accepted in idle, `cfg_req_n` goes low for exactly `REQ_CYC` cycles. `ser_clk` stays low the whole time `cfg_req_n` is low.
- R2: In the last cycle of the request-low window, `stat_n` must be low. If it is high, the block ends with `cfg_fail`=1 and `err_code`=1. It does not enter the release wait, it produces no serial clock and it takes no byte.
- R3: After the request is released, the block waits for `stat_n` to go high. If `stat_n` is not high within `TO_CYC` cycles, the load ends with `err_code`=2. `busy` is then high for exactly `REQ_CYC`+`TO_CYC` cycles.
- R4: Each accepted byte is sent as 8 bits, least significant bit first. Bytes are sent in the order they were accepted, and exactly `byte_len` bytes are taken.
- R5: For each bit, `ser_clk` is low while `ser_data` takes the new bit and then goes high. `ser_data` does not change while `ser_clk` is high. Every high phase lasts exactly `HALF_CYC` cycles, and every low phase inside a load lasts at least `HALF_CYC` cycles.
- R6: After the last byte, `cfg_done` is sampled. If it is low, the load ends with `cfg_fail`=1 and `err_code`=3, and no further clock edges are made.
- R7: If `cfg_done` is high, exactly `TRAIL_N` (12) further rising edges follow on `ser_clk`, each as a high phase then a low phase. Then the block returns to idle with `cfg_ok`=1 and `err_code`=0.
- R8: `in_ready` is high only in the data phase, when the shifter is empty and bytes remain. While `in_valid` is low there, the block stalls with `ser_clk` low.
- R9: `abort` during a load returns the block to idle on the next cycle. In idle, `cfg_req_n`=1, `ser_clk`=0 and `in_ready`=0, no further byte is taken, and neither `cfg_ok` nor `cfg_fail` is set.
- R10: Error codes are 0 none, 1 status not asserted, 2 status-release timeout and 3 done not set. `err_code`, `cfg_ok` and `cfg_fail` hold their values in idle and are cleared in the cycle after a start is accepted.
- R11: During and right after reset, the block is idle with `busy`=0, `cfg_req_n`=1, `ser_clk`=0, `ser_data`=0, `in_ready`=0, `cfg_ok`=0, `cfg_fail`=0 and `err_code`=0.
- R12: A load with `byte_len`=0 goes straight from the status release to the done check, so a successful load makes exactly 12 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a load when idle |
| abort | input | 1 | Stops a load in progress |
| byte_len | input | LEN_W | Number of bitstream bytes, captured at start |
| in_data | input | 8 | Bitstream byte |
| in_valid | input | 1 | Byte available |
| in_ready | output | 1 | Byte taken this cycle when valid |
| cfg_req_n | output | 1 | Active-low configuration request to the device |
| ser_clk | output | 1 | Serial configuration clock |
| ser_data | output | 1 | Serial configuration data |
| stat_n | input | 1 | Active-low device status |
| cfg_done | input | 1 | Device configuration-done flag |
| busy | output | 1 | Load in progress |
| cfg_ok | output | 1 | Last load succeeded |
| cfg_fail | output | 1 | Last load failed |
| err_code | output | 2 | Failure cause of last load |

## Verification
A wrong sequencer state shows up at the ports within one cycle. It can appear as a serial clock edge while the request is low, as ready raised outside the data phase, or as a phase counter running into the wrong state, which stretches or shortens a clock high phase. A wrong shifter or bit counter changes which bit lands on the rising edges. It shows up in the first byte rebuilt from the link, and as a total edge count other than eight per byte plus twelve. A wrong sticky status or timeout counter shows up only when the load ends, as a wrong error code or a busy length other than the request window plus the timeout.

// File: rtl/ps_cfg_master.sv
module ps_cfg_master #(
  parameter int REQ_CYC  = 100,
  parameter int TO_CYC   = 5_000_000,
  parameter int HALF_CYC = 1,
  parameter int LEN_W    = 24,
  parameter int TRAIL_N  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [LEN_W-1:0] byte_len,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             cfg_req_n,
  output logic             ser_clk,
  output logic             ser_data,
  input  logic             stat_n,
  input  logic             cfg_done,
  output logic             busy,
  output logic             cfg_ok,
  output logic             cfg_fail,
  output logic [1:0]       err_code
);

  localparam int T01  = (TO_CYC > REQ_CYC) ? TO_CYC : REQ_CYC;
  localparam int TMAX = (T01 > HALF_CYC) ? T01 : HALF_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int NW   = $clog2(TRAIL_N + 1);
  localparam logic [TW-1:0] REQ_END  = TW'(REQ_CYC - 1);
  localparam logic [TW-1:0] TO_END   = TW'(TO_CYC - 1);
  localparam logic [TW-1:0] HALF_END = TW'(HALF_CYC - 1);
  localparam logic [NW-1:0] TR_END   = NW'(TRAIL_N - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_WAIT, S_FETCH, S_LO, S_HI, S_CHK, S_THI, S_TLO
  } st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [7:0]       sh;
  logic [2:0]       bitn;
  logic [LEN_W-1:0] nbytes, len_q;
  logic [NW-1:0]    trail;

  assign busy      = (st != S_IDLE);
  assign cfg_req_n = (st != S_REQ);
  assign ser_clk   = (st == S_HI) || (st == S_THI);
  assign ser_data  = sh[0];
  assign in_ready  = (st == S_FETCH) && (nbytes != len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      sh       <= '0;
      bitn     <= '0;
      nbytes   <= '0;
      len_q    <= '0;
      trail    <= '0;
      cfg_ok   <= 1'b0;
      cfg_fail <= 1'b0;
      err_code <= 2'd0;
    end else if (st != S_IDLE && abort) begin
      st  <= S_IDLE;
      tmr <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_REQ;
          tmr      <= '0;
          len_q    <= byte_len;
          nbytes   <= '0;
          cfg_ok   <= 1'b0;
          cfg_fail <= 1'b0;
          err_code <= 2'd0;
        end
        S_REQ: if (tmr == REQ_END) begin
          tmr <= '0;
          if (!stat_n) st <= S_WAIT;
          else begin
            st       <= S_IDLE;
            cfg_fail <= 1'b1;
            err_code <= 2'd1;
          end
        end else tmr <= tmr + 1'b1;
        S_WAIT: if (stat_n) begin
          st  <= S_FETCH;
          tmr <= '0;
        end else if (tmr == TO_END) begin
          st       <= S_IDLE;
          tmr      <= '0;
          cfg_fail <= 1'b1;
          err_code <= 2'd2;
        end else tmr <= tmr + 1'b1;
        S_FETCH: if (nbytes == len_q) st <= S_CHK;
        else if (in_valid) begin
          sh     <= in_data;
          nbytes <= nbytes + 1'b1;
          bitn   <= '0;
          tmr    <= '0;
          st     <= S_LO;
        end
        S_LO: if (tmr == HALF_END) begin
          tmr <= '0;
          st  <= S_HI;
        end else tmr <= tmr + 1'b1;
        S_HI: if (tmr == HALF_END) begin
          tmr <= '0;
          sh  <= sh >> 1;
          if (bitn == 3'd7) st <= S_FETCH;
          else begin
            bitn <= bitn + 1'b1;
            st   <= S_LO;
          end
        end else tmr <= tmr + 1'b1;
        S_CHK: if (cfg_done) begin
          trail <= '0;
          tmr   <= '0;
          st    <= S_THI;
        end else begin
          st       <= S_IDLE;
          cfg_fail <= 1'b1;
          err_code <= 2'd3;
        end
        S_THI: if (tmr == HALF_END) begin
          tmr <= '0;
          st  <= S_TLO;
        end else tmr <= tmr + 1'b1;
        S_TLO: if (tmr == HALF_END) begin
          tmr <= '0;
          if (trail == TR_END) begin
            st     <= S_IDLE;
            cfg_ok <= 1'b1;
          end else begin
            trail <= trail + 1'b1;
            st    <= S_THI;
          end
        end else tmr <= tmr + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ps_cfg_master_chk.sv
module ps_cfg_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       abort,
  input logic       in_valid,
  input logic       in_ready,
  input logic       cfg_req_n,
  input logic       ser_clk,
  input logic       ser_data,
  input logic       busy,
  input logic       cfg_ok,
  input logic       cfg_fail,
  input logic [1:0] err_code
);

  // R1
  req_low_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req_n |-> !ser_clk);

  // R5
  hi_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk && $past(ser_clk) |-> $stable(ser_data));

  // R8
  ready_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy && cfg_req_n && !ser_clk);

  // R8
  stall_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid && !abort |=> !ser_clk);

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort && busy |=> !busy && cfg_req_n && !ser_clk && !in_ready && !cfg_ok && !cfg_fail);

  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && err_code == 2'd0 && !cfg_ok && !cfg_fail);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(err_code) && $stable(cfg_ok) && $stable(cfg_fail));

  // R10
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fail |-> err_code != 2'd0 && !cfg_ok);

  // R7
  ok_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> err_code == 2'd0 && !busy);

endmodule

bind ps_cfg_master ps_cfg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
  .in_valid(in_valid), .in_ready(in_ready), .cfg_req_n(cfg_req_n),
  .ser_clk(ser_clk), .ser_data(ser_data), .busy(busy),
  .cfg_ok(cfg_ok), .cfg_fail(cfg_fail), .err_code(err_code)
);

// File: tb/ps_cfg_master_tb_top.sv
module ps_cfg_master_tb_top;
  localparam int CLK_P = 10;
  localparam int T_REQ = 4;
  localparam int T_TO  = 60;
  localparam int HALF  = 2;
  localparam int LW    = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
  logic [LW-1:0] byte_len = '0;
  logic [7:0] in_data;
  logic in_valid, in_ready, cfg_req_n, ser_clk, ser_data;
  logic stat_n, cfg_done = 1'b1, busy, cfg_ok, cfg_fail;
  logic [1:0] err_code;

  always #(CLK_P/2) clk = ~clk;

  ps_cfg_master #(.REQ_CYC(T_REQ), .TO_CYC(T_TO), .HALF_CYC(HALF), .LEN_W(LW), .TRAIL_N(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .byte_len(byte_len),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_req_n(cfg_req_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .stat_n(stat_n), .cfg_done(cfg_done), .busy(busy),
    .cfg_ok(cfg_ok), .cfg_fail(cfg_fail), .err_code(err_code));

  int n_chk = 0, n_err = 0;
  bit fin = 0;
  int run_id = 0;
  int src_len = 0;
  bit src_gap = 0;
  int smode = 0;

  function automatic logic [7:0] pat(input logic [7:0] s, input int k);
    return s ^ 8'(k * 37);
  endfunction

  task automatic check(input bit c, input string rq, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // link monitor
  int seen_m = 0, rise = 0, rx_bits = 0, req_lo = 0, busy_cyc = 0, hi_run = 0, mon_bad = 0;
  logic [7:0] rx_sh = '0;
  logic [7:0] rx_mem [32];
  logic p_clk = 1'b0, p_data = 1'b0;
  always @(negedge clk) begin
    if (seen_m != run_id) begin
      seen_m = run_id; rise = 0; rx_bits = 0; req_lo = 0; busy_cyc = 0; hi_run = 0; mon_bad = 0;
    end
    if (!cfg_req_n) req_lo++;
    if (busy) busy_cyc++;
    if (!cfg_req_n && ser_clk) mon_bad++;
    if (ser_clk && p_clk && ser_data != p_data) mon_bad++;
    if (ser_clk && !p_clk) begin
      rise++;
      rx_sh = {ser_data, rx_sh[7:1]};
      rx_bits++;
      if (rx_bits % 8 == 0 && rx_bits / 8 <= 32) rx_mem[rx_bits/8 - 1] = rx_sh;
    end
    if (ser_clk) hi_run++;
    else if (p_clk) begin
      if (hi_run != HALF) mon_bad++;
      hi_run = 0;
    end
    p_clk = ser_clk; p_data = ser_data;
  end

  // byte source
  int seen_s = 0, src_idx = 0, cyc = 0;
  logic [7:0] src_seed = '0;
  logic vld_q = 1'b0, rdy_q = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (seen_s != run_id) begin
      seen_s = run_id; src_idx = 0; vld_q = 1'b0; rdy_q = 1'b0;
    end
    if (vld_q && rdy_q) src_idx++;
    in_valid = (src_idx < src_len) && !(src_gap && (cyc % 5 == 2));
    in_data  = pat(src_seed, src_idx);
    vld_q = in_valid;
    rdy_q = in_ready;
  end

  // device status model
  int rel = 5;
  always @(negedge clk) begin
    case (smode)
      0: if (!cfg_req_n) begin stat_n = 1'b0; rel = 0; end
         else if (rel < 5) rel++;
         else stat_n = 1'b1;
      1: stat_n = 1'b1;
      default: stat_n = 1'b0;
    endcase
  end
  initial stat_n = 1'b1;

  // len, seed, status mode, done, gap, expected error
  localparam logic [21:0] VECS [7] = '{
    {8'd4, 8'hA5, 2'd0, 1'b1, 1'b0, 2'd0},
    {8'd3, 8'h3C, 2'd0, 1'b1, 1'b1, 2'd0},
    {8'd1, 8'h80, 2'd0, 1'b1, 1'b0, 2'd0},
    {8'd0, 8'h00, 2'd0, 1'b1, 1'b0, 2'd0},
    {8'd2, 8'h11, 2'd1, 1'b1, 1'b0, 2'd1},
    {8'd2, 8'h22, 2'd2, 1'b1, 1'b0, 2'd2},
    {8'd2, 8'h5A, 2'd0, 1'b0, 1'b0, 2'd3}
  };

  task automatic launch(input int len, input logic [7:0] seed, input int sm,
                        input bit dn, input bit gp, input int extra);
    @(posedge clk);
    run_id++;
    src_len = len + extra; src_gap = gp; src_seed = seed; smode = sm;
    cfg_done = dn; byte_len = LW'(len);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && err_code == 0 && !cfg_ok && !cfg_fail, "R10 start clears status", err_code, 0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!fin) begin
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && cfg_req_n && !ser_clk && !ser_data && !in_ready, "R11 outputs in reset", busy, 0);
    check(!cfg_ok && !cfg_fail && err_code == 0, "R11 status in reset", err_code, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && cfg_req_n && !ser_clk && !in_ready && err_code == 0, "R11 idle after reset", busy, 0);

    foreach (VECS[v]) begin
      int len, sm, ex, bad, exp_rise, exp_take;
      bit dn, gp;
      logic [7:0] sd;
      {len, sd, sm, dn, gp, ex} = {24'd0, VECS[v][21:14], VECS[v][13:6], 30'd0, VECS[v][5:4],
                                   VECS[v][3], VECS[v][2], 30'd0, VECS[v][1:0]};
      launch(len, sd, sm, dn, gp, 0);
      wait_idle();
      exp_rise = (ex == 0) ? 8*len + 12 : (ex == 3) ? 8*len : 0;
      exp_take = (ex == 1 || ex == 2) ? 0 : len;
      check(err_code == 2'(ex), "R10 R2 R3 R6 error code", err_code, ex);
      check(cfg_ok == (ex == 0) && cfg_fail == (ex != 0), "R7 R6 ok/fail flags", cfg_ok, ex == 0);
      check(rise == exp_rise, (len == 0) ? "R12 R7 rising edges" : "R7 R6 R2 rising edges", rise, exp_rise);
      check(req_lo == T_REQ, "R1 request low length", req_lo, T_REQ);
      check(src_idx == exp_take, "R8 R2 bytes taken", src_idx, exp_take);
      bad = 0;
      for (int k = 0; k < exp_take && ex != 1 && ex != 2; k++)
        if (rx_mem[k] !== pat(sd, k)) bad++;
      check(bad == 0, "R4 bytes on link", bad, 0);
      check(mon_bad == 0, "R5 clock phases and data setup", mon_bad, 0);
      if (ex == 2) check(busy_cyc == T_REQ + T_TO, "R3 timeout length", busy_cyc, T_REQ + T_TO);
      repeat (10) @(negedge clk);
      check(err_code == 2'(ex) && !busy, "R10 status held in idle", err_code, ex);
    end

    // R9 abort mid-load
    begin
      int taken, r0;
      launch(6, 8'h6B, 0, 1'b1, 1'b0, 4);
      for (int i = 0; i < 2000 && rise < 10; i++) @(negedge clk);
      abort = 1'b1;
      @(negedge clk); abort = 1'b0;
      check(!busy && cfg_req_n && !ser_clk && !in_ready, "R9 idle after abort", busy, 0);
      check(!cfg_ok && !cfg_fail && err_code == 0, "R9 no result after abort", err_code, 0);
      taken = src_idx; r0 = rise;
      repeat (40) @(negedge clk);
      check(src_idx == taken, "R9 no byte taken after abort", src_idx, taken);
      check(rise == r0, "R9 no clock after abort", rise, r0);
    end

    // recovery after abort, with stalls
    launch(5, 8'hC3, 0, 1'b1, 1'b1, 0);
    wait_idle();
    check(cfg_ok && err_code == 0 && rise == 8*5 + 12, "R7 load after abort", rise, 52);
    begin
      int bad = 0;
      for (int k = 0; k < 5; k++) if (rx_mem[k] !== pat(8'hC3, k)) bad++;
      check(bad == 0, "R4 bytes after abort", bad, 0);
    end
    check(mon_bad == 0, "R5 phases with stalls", mon_bad, 0);

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule